// File: doc/BRIEF.md
# Sixteen-Bit ALU with Status Flags

This block is the execute stage of a small 16-bit processor. Each cycle in which `in_valid` is high it takes two operands, a 4-bit immediate, an operation code and the current status word. It computes one of sixteen operations: additions, subtractions, bitwise operations and shifts, in register and immediate forms. On the next rising clock edge it registers the result, a write strobe for the register file, and the updated status word.

The status word carries three condition flags: zero at bit 2, carry at bit 3 and negative at bit 4. Every other status bit passes through unchanged, including the two interrupt-enable bits at positions 0 and 1. Arithmetic and shift operations form a 17-bit value and update all three flags. Bitwise operations update only zero and negative and keep the incoming carry. Register read, instruction decode and the choice of destination are handled outside this block.

Top module: `alu16_core`

## Requirements
- R1: Outputs are registered with one cycle of latency. `wr_en_o` is high in the cycle after an accepted operation that writes a result, and low in every other cycle. When `in_valid` is low, `result_o` and `status_o` hold their values.
- R2: Operation codes 0 (opa+opb), 1 (opa+opb+C), 2 (0−opa), 3 (opa−opb) and 11 (opa+immediate) form a 17-bit value. Z is set when its low 16 bits are zero, N copies bit 15, and C copies bit 16, which is the borrow for a subtraction.
- R3: Code 1 adds one more when status bit 3 (C) of `status_i` is set.
- R4: Code 3 (compare) updates Z, C and N as in R2. It does not write a result: `wr_en_o` stays low and `result_o` keeps its previous value.
- R5: Codes 4 (AND), 5 (OR), 6 (XOR), 7 (NOT opa), 12 (AND immediate) and 13 (OR immediate) set Z and N from the result and copy C from `status_i`.
- R6: The immediate for codes 12 and 13 is `imm` sign-extended from bit 3. Code 11 uses the same extension, except that `imm`=0 adds 8.
- R7: Code 8 shifts opa left by opb[3:0] and sets C from bit 16 of the 17-bit shifted value. For any register shift (codes 8, 9, 10), an amount of 0 returns opa unchanged with C cleared.
- R8: Code 9 shifts right with zero fill and code 10 shifts right filling with opa[15]. Both set C to opa[amount−1], the last bit shifted out.
- R9: Code 14 shifts opa by `imm[2:0]`, where 0 means 8. `imm[3]`=1 selects a logical right shift and `imm[3]`=0 a left shift, with C as in R7 and R8.
- R10: Code 15 shifts opa arithmetically right by `imm`, where 0 means 16. A 16-place shift returns sixteen copies of opa[15] with C = opa[15].
- R11: Status bits 0, 1 and 5 to 15 of `status_o` equal those of `status_i` for every accepted operation.
- R12: While `rst_n` is low, `result_o`, `wr_en_o` and `status_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Accept the operation on this edge |
| op_sel | input | 4 | Operation code (see requirements) |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand or register shift amount |
| imm | input | 4 | Immediate field |
| status_i | input | 16 | Current status word |
| result_o | output | 16 | Registered result |
| wr_en_o | output | 1 | Result write strobe |
| status_o | output | 16 | Registered new status word |

## Verification
The assertions check on every cycle that the zero and negative flags agree with any written result, and that the pass-through status bits are copied. They also check that compare never writes, that bitwise operations keep the carry, and that the outputs hold while idle. Only the bench's scenarios can show that the arithmetic values, the carry and borrow bits, and the shift fills are correct. The same applies to the special immediate encodings: zero meaning 8 for add and shift, and zero meaning 16 for the immediate arithmetic shift. The bench compares these against its own model on random and directed operands.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_NEG  = 4'd2,  OP_CMP  = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_NOT  = 4'd7,
    OP_SHL  = 4'd8,  OP_SHR  = 4'd9,  OP_ASR  = 4'd10, OP_ADDI = 4'd11,
    OP_ANDI = 4'd12, OP_ORI  = 4'd13, OP_SHI  = 4'd14, OP_ASRI = 4'd15
  } alu_op_e;

  localparam int FLG_Z = 2;
  localparam int FLG_C = 3;
  localparam int FLG_N = 4;
endpackage

// File: rtl/alu16_rst_sync.sv
module alu16_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub
  import alu16_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] immx,
  input  logic          cin,
  output logic [DW:0]   sum
);
  localparam logic [DW-1:0] IMM_ZERO_VAL = DW'(1 << (IW - 1));

  logic [DW-1:0] x, y;
  logic          ci, sub;

  always_comb begin
    x   = a;
    y   = b;
    ci  = 1'b0;
    sub = 1'b0;
    case (op)
      OP_ADC:  ci = cin;
      OP_NEG:  begin x = '0; y = a; sub = 1'b1; end
      OP_CMP:  sub = 1'b1;
      OP_ADDI: y = (immx == '0) ? IMM_ZERO_VAL : immx;
      default: ;
    endcase
    if (sub) sum = {1'b0, x} - {1'b0, y};
    else     sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] immx,
  output logic [DW-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_ANDI: res = a & immx;
      OP_ORI:  res = a | immx;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int LW = $clog2(DW);
  localparam int SW = $clog2(DW + 1);
  localparam logic [SW-1:0] SHI_ZERO  = SW'(1 << (IW - 1));
  localparam logic [SW-1:0] ASRI_ZERO = SW'(DW);

  logic [SW-1:0]   amt;
  logic            right, fill;
  logic [2*DW:0]   rext;
  logic [DW:0]     lext;

  always_comb begin
    amt   = SW'(b[LW-1:0]);
    right = 1'b0;
    fill  = 1'b0;
    case (op)
      OP_SHR:  right = 1'b1;
      OP_ASR:  begin right = 1'b1; fill = a[DW-1]; end
      OP_SHI:  begin
        amt   = (imm[IW-2:0] == '0) ? SHI_ZERO : SW'(imm[IW-2:0]);
        right = imm[IW-1];
      end
      OP_ASRI: begin
        amt   = (imm == '0) ? ASRI_ZERO : SW'(imm);
        right = 1'b1;
        fill  = a[DW-1];
      end
      default: ;
    endcase
    rext = {{DW{fill}}, a, 1'b0} >> amt;
    lext = {1'b0, a} << amt;
    if (right) begin
      res  = rext[DW:1];
      cout = rext[0];
    end else begin
      res  = lext[DW-1:0];
      cout = lext[DW];
    end
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [IW-1:0] imm,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] result_o,
  output logic          wr_en_o,
  output logic [DW-1:0] status_o
);
  alu_op_e       op;
  logic          rst_sync_n;
  logic [DW-1:0] immx;
  logic [DW:0]   sum;
  logic [DW-1:0] log_res, sh_res;
  logic          sh_c;
  logic          is_logic, is_shift;
  logic [DW-1:0] res_d, st_d;
  logic          carry_d, wr_d, res_en;
  logic [DW-1:0] res_q, st_q;
  logic          wr_q;

  assign op   = alu_op_e'(op_sel);
  assign immx = {{(DW-IW){imm[IW-1]}}, imm};

  alu16_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(rst_sync_n));

  alu16_addsub #(.DW(DW), .IW(IW)) u_addsub (
    .op(op), .a(opa), .b(opb), .immx(immx), .cin(status_i[FLG_C]), .sum(sum));

  alu16_logic #(.DW(DW)) u_logic (
    .op(op), .a(opa), .b(opb), .immx(immx), .res(log_res));

  alu16_shift #(.DW(DW), .IW(IW)) u_shift (
    .op(op), .a(opa), .b(opb), .imm(imm), .res(sh_res), .cout(sh_c));

  always_comb begin
    is_logic = op inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ANDI, OP_ORI};
    is_shift = op inside {OP_SHL, OP_SHR, OP_ASR, OP_SHI, OP_ASRI};
    carry_d  = status_i[FLG_C];
    if (is_logic) begin
      res_d = log_res;
    end else if (is_shift) begin
      res_d   = sh_res;
      carry_d = sh_c;
    end else begin
      res_d   = sum[DW-1:0];
      carry_d = sum[DW];
    end
    st_d        = status_i;
    st_d[FLG_Z] = (res_d == '0);
    st_d[FLG_N] = res_d[DW-1];
    st_d[FLG_C] = carry_d;
    wr_d        = in_valid && (op != OP_CMP);
    res_en      = wr_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      st_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= wr_d;
      if (res_en)   res_q <= res_d;
      if (in_valid) st_q  <= st_d;
    end
  end

  assign result_o = res_q;
  assign status_o = st_q;
  assign wr_en_o  = wr_q;
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          srst_n,
  input logic          in_valid,
  input logic [3:0]    op_sel,
  input logic [DW-1:0] status_i,
  input logic [DW-1:0] result_o,
  input logic          wr_en_o,
  input logic [DW-1:0] status_o
);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> (!wr_en_o && $stable(result_o) && $stable(status_o)));

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en_o |-> (status_o[2] == (result_o == '0)));

  p_neg_flag_r2: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en_o |-> (status_o[4] == result_o[DW-1]));

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && op_sel == 4'd3) |=> (!wr_en_o && $stable(result_o)));

  p_logic_carry_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && op_sel inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13})
      |=> (status_o[3] == $past(status_i[3])));

  p_passthru_r11: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> (status_o[1:0] == $past(status_i[1:0]) &&
                  status_o[DW-1:5] == $past(status_i[DW-1:5])));
endmodule

bind alu16_core alu16_chk #(.DW(DW)) u_chk (
  .clk(clk), .srst_n(rst_sync_n), .in_valid(in_valid), .op_sel(op_sel),
  .status_i(status_i), .result_o(result_o), .wr_en_o(wr_en_o), .status_o(status_o));

// File: tb/alu16_core_tb.sv
module alu16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [15:0] opa = '0, opb = '0, status_i = '0;
  logic [3:0]  imm = '0;
  logic [15:0] result_o, status_o;
  logic        wr_en_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] last_res = '0;

  always #5 clk = ~clk;

  alu16_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .imm(imm), .status_i(status_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .status_o(status_o));

  function automatic logic [16:0] f_shl(input logic [15:0] a, input int n);
    logic [31:0] w;
    w = {16'h0, a} << n;
    return w[16:0];
  endfunction

  function automatic logic [16:0] f_shr(input logic [15:0] a, input int n, input bit sgn);
    logic [31:0] w, r;
    logic c;
    w = (sgn && a[15]) ? {16'hFFFF, a} : {16'h0000, a};
    r = w >> n;
    c = (n == 0) ? 1'b0 : w[n-1];
    return {c, r[15:0]};
  endfunction

  // returns {wr, result, status}
  function automatic logic [32:0] model(input logic [3:0] op, input logic [15:0] a, b,
                                        input logic [3:0] im, input logic [15:0] st);
    logic [16:0] t;
    logic [15:0] ix, ns;
    logic wr, ar;
    int n;
    ix = {{12{im[3]}}, im};
    wr = 1'b1; ar = 1'b1; t = '0;
    case (op)
      4'd0:  t = {1'b0, a} + {1'b0, b};
      4'd1:  t = {1'b0, a} + {1'b0, b} + {16'h0, st[3]};
      4'd2:  t = 17'd0 - {1'b0, a};
      4'd3:  begin t = {1'b0, a} - {1'b0, b}; wr = 1'b0; end
      4'd4:  begin ar = 1'b0; t = {1'b0, a & b}; end
      4'd5:  begin ar = 1'b0; t = {1'b0, a | b}; end
      4'd6:  begin ar = 1'b0; t = {1'b0, a ^ b}; end
      4'd7:  begin ar = 1'b0; t = {1'b0, ~a}; end
      4'd8:  t = f_shl(a, int'(b[3:0]));
      4'd9:  t = f_shr(a, int'(b[3:0]), 1'b0);
      4'd10: t = f_shr(a, int'(b[3:0]), 1'b1);
      4'd11: t = {1'b0, a} + {1'b0, (im == 4'd0) ? 16'd8 : ix};
      4'd12: begin ar = 1'b0; t = {1'b0, a & ix}; end
      4'd13: begin ar = 1'b0; t = {1'b0, a | ix}; end
      4'd14: begin
        n = (im[2:0] == 3'd0) ? 8 : int'(im[2:0]);
        t = im[3] ? f_shr(a, n, 1'b0) : f_shl(a, n);
      end
      default: begin
        n = (im == 4'd0) ? 16 : int'(im);
        t = f_shr(a, n, 1'b1);
      end
    endcase
    ns = st;
    ns[2] = (t[15:0] == 16'h0);
    ns[4] = t[15];
    if (ar) ns[3] = t[16];
    return {wr, t[15:0], ns};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act wr=%0b res=%h st=%h exp wr=%0b res=%h st=%h",
               req, act[32], act[31:16], act[15:0], exp[32], exp[31:16], exp[15:0]);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic run_op(input string req, input logic [3:0] op, input logic [15:0] a, b,
                        input logic [3:0] im, input logic [15:0] st);
    logic [32:0] e;
    e = model(op, a, b, im, st);
    if (!e[32]) e[31:16] = last_res; // compare keeps the result register (R4)
    in_valid = 1'b1; op_sel = op; opa = a; opb = b; imm = im; status_i = st;
    @(negedge clk);
    check(req, {wr_en_o, result_o, status_o}, e);
    last_res = result_o;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R12 reset", {wr_en_o, result_o, status_o}, 33'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 after release", {wr_en_o, result_o, status_o}, 33'h0);

    run_op("R2 add carry out", 4'd0, 16'hFFFF, 16'h0001, 4'd0, 16'h0000);
    run_op("R3 adc with C", 4'd1, 16'h1234, 16'h0001, 4'd0, 16'h0008);
    run_op("R3 adc without C", 4'd1, 16'h1234, 16'h0001, 4'd0, 16'h0000);
    run_op("R2 neg zero", 4'd2, 16'h0000, 16'h0, 4'd0, 16'h0008);
    run_op("R2 neg one", 4'd2, 16'h0001, 16'h0, 4'd0, 16'h0000);
    run_op("R4 cmp equal", 4'd3, 16'h5555, 16'h5555, 4'd0, 16'h0000);
    run_op("R4 cmp borrow", 4'd3, 16'h0001, 16'h0002, 4'd0, 16'h0000);
    run_op("R5 and keeps C", 4'd4, 16'hF0F0, 16'h0F0F, 4'd0, 16'h0008);
    run_op("R5 not keeps C", 4'd7, 16'h0000, 16'h0, 4'd0, 16'h0008);
    run_op("R6 addi zero means 8", 4'd11, 16'h0010, 16'h0, 4'd0, 16'h0000);
    run_op("R6 addi minus one", 4'd11, 16'h0000, 16'h0, 4'hF, 16'h0000);
    run_op("R6 andi sign ext", 4'd12, 16'h1234, 16'h0, 4'h8, 16'h0000);
    run_op("R6 ori positive", 4'd13, 16'h1230, 16'h0, 4'h7, 16'h0008);
    run_op("R7 shl by 0", 4'd8, 16'h8001, 16'h0010, 4'd0, 16'h0008);
    run_op("R7 shl by 15", 4'd8, 16'h0003, 16'h000F, 4'd0, 16'h0000);
    run_op("R8 shr last bit out", 4'd9, 16'h0004, 16'h0003, 4'd0, 16'h0000);
    run_op("R8 shr by 0", 4'd9, 16'h8001, 16'h0000, 4'd0, 16'h0008);
    run_op("R8 asr fill", 4'd10, 16'h8000, 16'h0004, 4'd0, 16'h0000);
    run_op("R9 shi zero means left 8", 4'd14, 16'h01FF, 16'h0, 4'h0, 16'h0000);
    run_op("R9 shi right 8", 4'd14, 16'h0180, 16'h0, 4'h8, 16'h0000);
    run_op("R9 shi right 3", 4'd14, 16'h000C, 16'h0, 4'hB, 16'h0000);
    run_op("R10 asri 16", 4'd15, 16'h8000, 16'h0, 4'h0, 16'h0000);
    run_op("R10 asri 16 positive", 4'd15, 16'h7FFF, 16'h0, 4'h0, 16'h0008);
    run_op("R11 passthru bits", 4'd0, 16'h0001, 16'h0001, 4'd0, 16'hFFE3);

    // R1 idle: outputs hold while inputs change
    begin
      logic [32:0] held;
      held = {1'b0, result_o, status_o};
      in_valid = 1'b0; op_sel = 4'd0; opa = 16'h7777; opb = 16'h1111; status_i = 16'hFFFF;
      @(negedge clk);
      check("R1 idle hold", {wr_en_o, result_o, status_o}, held);
      @(negedge clk);
      check("R1 idle hold 2", {wr_en_o, result_o, status_o}, held);
    end

    for (int i = 0; i < 600; i++) begin
      logic [15:0] ra, rb, rs;
      logic [3:0]  ro, ri;
      ra = 16'($urandom); rb = 16'($urandom); rs = 16'($urandom);
      ro = 4'($urandom); ri = 4'($urandom);
      if (i % 4 == 0) rb = rb & 16'h000F;
      run_op("R1-random", ro, ra, rb, ri, rs);
    end

    in_valid = 1'b0;
    @(negedge clk);
    check("R1 strobe drops", {32'h0, wr_en_o}, 33'h0);
    rst_n = 1'b0;
    #1;
    check("R12 async reset", {wr_en_o, result_o, status_o}, 33'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule